// File: doc/BRIEF.md
# Miss-driven cache size controller

This block decides how much of a set-partitioned cache stays powered. The cache is split into a power-of-two number of equal sections. The active size is always a power-of-two count of sections, from a configurable floor up to the whole cache. The block watches two event streams: one pulse for each cache miss and one pulse for each retired instruction. It groups the instruction pulses into intervals of configurable length. When an interval closes, it compares the misses counted in that interval with a programmable threshold. A count above the threshold doubles the active size. A count below it halves the active size. A count equal to it leaves the size alone.

The block drives three things from the resulting size. The first is a per-section enable mask for the supply-gating switches. The second is the number of set-index bits now in use, which the lookup logic needs because resizing moves the set mapping. The third is a one-cycle request that fires on every size change, so the cache can invalidate lines whose mapping has moved.

Top module: `cache_resize_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the size level (`size_lvl`) is log2(NUM_SECTIONS), which is 3 with the defaults. All bits of `section_en` are 1, `index_bits` equals SETS_LOG2, and `resize_req` is 0.
- R2: An interval closes on the clock edge that samples its `cfg_interval_len`-th `retire_pulse`, counted from the previous close. A value of 0 behaves as 1. Cycles without `retire_pulse` do not advance the interval.
- R3: At a close, a miss count strictly greater than `cfg_threshold` raises the level by one. The level does not rise above log2(NUM_SECTIONS).
- R4: At a close, a miss count strictly less than `cfg_threshold` lowers the level by one.
- R5: At a close, a miss count equal to `cfg_threshold` leaves the level unchanged.
- R6: A decrease never takes the level below `cfg_min_lvl`. At the floor, a low-miss interval leaves the level unchanged.
- R7: Bit i of `section_en` is 1 exactly when i < 2^level. The mask follows the level from the cycle after the closing edge.
- R8: `index_bits` equals SETS_LOG2 - log2(NUM_SECTIONS) + level.
- R9: `resize_req` is 1 for the single cycle after a closing edge that changed the level, and 0 otherwise.
- R10: The miss count saturates at all ones instead of wrapping. A miss sampled on the closing edge counts toward the closing interval. Both the miss count and the instruction count restart from zero after each close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_pulse | input | 1 | One cache miss in this cycle |
| retire_pulse | input | 1 | One retired instruction in this cycle |
| cfg_interval_len | input | INTERVAL_W | Instructions per interval (0 acts as 1) |
| cfg_threshold | input | MISS_W | Miss threshold compared at each close |
| cfg_min_lvl | input | LVL_W | Lowest allowed level (log2 of sections) |
| section_en | output | NUM_SECTIONS | Per-section supply enable |
| index_bits | output | IDX_W | Set-index bits currently in use |
| size_lvl | output | LVL_W | Current level, log2 of active sections |
| resize_req | output | 1 | One-cycle pulse on a size change |

## Verification
Suppose the interval counter fails to restart after a close. The next size decision then arrives one or more retire pulses too early or too late. The bench exposes this by checking that the level holds one retire before the expected close and moves on that close.

A miss count that wraps or carries over between intervals shows up as a step in the wrong direction at the very next close. The bench builds interval patterns where the correct count and the broken count fall on opposite sides of the threshold.

A level register out of step with the mask or the index width would misreport the size on the cycle right after the closing edge. The bench samples all outputs in that cycle.

// File: rtl/cache_resize_pkg.sv
// Shared types for the miss-driven cache size controller.
// Assumes nothing beyond standard SystemVerilog packages.
package cache_resize_pkg;

    // Outcome of one interval close
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_GROW   = 2'd1,
        STEP_SHRINK = 2'd2
    } step_e;

    // Choose a step from the comparison result and the current bounds
    function automatic step_e pick_step(input logic above, input logic below,
                                        input logic at_top, input logic at_floor);
        step_e s;
        s = STEP_HOLD;
        if (above && !at_top)
            s = STEP_GROW;
        else if (below && !at_floor)
            s = STEP_SHRINK;
        return s;
    endfunction

endpackage

// File: rtl/crc_interval_timer.sv
// Counts retired instructions and flags the retire pulse that closes an interval.
// Assumes: a length of 0 behaves as 1; the count restarts from zero after each close.
module crc_interval_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic [CNT_W-1:0] len,
    output logic             close
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;

    // Count this retire and test it against the interval length
    always_comb begin
        cnt_inc = {1'b0, cnt} + 1'b1;
        close   = retire && (cnt_inc >= {1'b0, len});
    end

    // Advance on a retire, restart on a close
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (close)
            cnt <= '0;
        else if (retire)
            cnt <= cnt_inc[CNT_W-1:0];
    end
endmodule

// File: rtl/crc_miss_tally.sv
// Saturating count of miss pulses within the current interval.
// Assumes: `total` includes a miss in the current cycle; `clear` restarts from zero.
module crc_miss_tally #(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss,
    input  logic              clear,
    output logic [MISS_W-1:0] total
);
    logic [MISS_W-1:0] cnt;

    // Add the current miss, stopping at all ones
    always_comb begin
        if (miss && (cnt != {MISS_W{1'b1}}))
            total = cnt + 1'b1;
        else
            total = cnt;
    end

    // Keep the running total, or clear it at an interval close
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else
            cnt <= total;
    end
endmodule

// File: rtl/crc_size_step.sv
// Decides the next size level when an interval closes.
// Assumes: the level is log2 of active sections, and MAX_LVL fits in LVL_W bits.
module crc_size_step
    import cache_resize_pkg::*;
#(
    parameter int LVL_W   = 2,
    parameter int MISS_W  = 16,
    parameter int MAX_LVL = 3
) (
    input  logic              close,
    input  logic [MISS_W-1:0] misses,
    input  logic [MISS_W-1:0] threshold,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [LVL_W-1:0]  min_lvl,
    output logic [LVL_W-1:0]  next_lvl,
    output logic              changed
);
    step_e step;

    // Compare the count with the threshold and move the level one step
    always_comb begin
        step     = pick_step(misses > threshold, misses < threshold,
                             lvl >= LVL_W'(MAX_LVL), lvl <= min_lvl);
        next_lvl = lvl;
        changed  = 1'b0;
        if (close) begin
            case (step)
                STEP_GROW: begin
                    next_lvl = lvl + 1'b1;
                    changed  = 1'b1;
                end
                STEP_SHRINK: begin
                    next_lvl = lvl - 1'b1;
                    changed  = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/crc_section_decode.sv
// Turns a size level into a thermometer enable mask, one bit per section.
// Assumes: NUM_SECTIONS is a power of two and at least 2.
module crc_section_decode #(
    parameter int NUM_SECTIONS = 8,
    parameter int LVL_W        = 2
) (
    input  logic [LVL_W-1:0]        lvl,
    output logic [NUM_SECTIONS-1:0] en
);
    localparam int NSEC_LOG2 = $clog2(NUM_SECTIONS);
    localparam int ACT_W     = NSEC_LOG2 + 1;

    logic [ACT_W-1:0] active_cnt;

    // Number of powered sections
    always_comb active_cnt = ACT_W'(1) << lvl;

    // Section i is powered when it lies below the active count
    for (genvar i = 0; i < NUM_SECTIONS; i++) begin : g_sec
        assign en[i] = ACT_W'(i) < active_cnt;
    end
endmodule

// File: rtl/cache_resize_ctrl.sv
// Top level: adapts the powered cache size from the miss count of each interval.
// Assumes: single clock, synchronous active-low reset, one event per pulse input per cycle.
module cache_resize_ctrl #(
    parameter int NUM_SECTIONS = 8,
    parameter int SETS_LOG2    = 10,
    parameter int INTERVAL_W   = 20,
    parameter int MISS_W       = 16,
    parameter int NSEC_LOG2    = $clog2(NUM_SECTIONS),
    parameter int LVL_W        = $clog2(NSEC_LOG2 + 1),
    parameter int IDX_W        = $clog2(SETS_LOG2 + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_pulse,
    input  logic                    retire_pulse,
    input  logic [INTERVAL_W-1:0]   cfg_interval_len,
    input  logic [MISS_W-1:0]       cfg_threshold,
    input  logic [LVL_W-1:0]        cfg_min_lvl,
    output logic [NUM_SECTIONS-1:0] section_en,
    output logic [IDX_W-1:0]        index_bits,
    output logic [LVL_W-1:0]        size_lvl,
    output logic                    resize_req
);
    localparam int IDX_BASE = SETS_LOG2 - NSEC_LOG2;

    logic              close;
    logic [MISS_W-1:0] miss_total;
    logic [LVL_W-1:0]  lvl_q;
    logic [LVL_W-1:0]  lvl_d;
    logic              lvl_changed;

    crc_interval_timer #(.CNT_W(INTERVAL_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .retire (retire_pulse),
        .len    (cfg_interval_len),
        .close  (close)
    );

    crc_miss_tally #(.MISS_W(MISS_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .miss  (miss_pulse),
        .clear (close),
        .total (miss_total)
    );

    crc_size_step #(.LVL_W(LVL_W), .MISS_W(MISS_W), .MAX_LVL(NSEC_LOG2)) u_step (
        .close     (close),
        .misses    (miss_total),
        .threshold (cfg_threshold),
        .lvl       (lvl_q),
        .min_lvl   (cfg_min_lvl),
        .next_lvl  (lvl_d),
        .changed   (lvl_changed)
    );

    crc_section_decode #(.NUM_SECTIONS(NUM_SECTIONS), .LVL_W(LVL_W)) u_decode (
        .lvl (lvl_q),
        .en  (section_en)
    );

    // Hold the level and raise the resize pulse on a change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q      <= LVL_W'(NSEC_LOG2);
            resize_req <= 1'b0;
        end else begin
            lvl_q      <= lvl_d;
            resize_req <= lvl_changed;
        end
    end

    // Publish the level and the number of index bits in use
    always_comb begin
        size_lvl   = lvl_q;
        index_bits = IDX_W'(IDX_BASE) + IDX_W'(lvl_q);
    end
endmodule

// File: rtl/cache_resize_ctrl_chk.sv
// Property checker for cache_resize_ctrl, attached through bind.
module cache_resize_ctrl_chk #(
    parameter int NUM_SECTIONS = 8,
    parameter int LVL_W        = 2,
    parameter int IDX_W        = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LVL_W-1:0]        cfg_min_lvl,
    input logic [NUM_SECTIONS-1:0] section_en,
    input logic [IDX_W-1:0]        index_bits,
    input logic [LVL_W-1:0]        size_lvl,
    input logic                    resize_req
);
    // R9: a pulse goes with a level change
    assert_req_has_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resize_req |-> (size_lvl != $past(size_lvl)));

    // R9: no pulse, no change
    assert_quiet_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !resize_req |-> $stable(size_lvl));

    // R3/R4: each change is a single doubling or halving
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resize_req |-> ((size_lvl == $past(size_lvl) + 1'b1) ||
                        (size_lvl == $past(size_lvl) - 1'b1)));

    // R6: a decrease stops at the floor
    assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resize_req && (size_lvl < $past(size_lvl))) |-> (size_lvl >= $past(cfg_min_lvl)));

    // R7: section 0 always powered and the powered count is a power of two
    assert_mask_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        section_en[0] && ($countones(section_en) == (1 << size_lvl)));

    // R8: index width moves together with the level
    assert_index_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(index_bits) == $stable(size_lvl));
endmodule

bind cache_resize_ctrl cache_resize_ctrl_chk #(
    .NUM_SECTIONS (NUM_SECTIONS),
    .LVL_W        (LVL_W),
    .IDX_W        (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_min_lvl (cfg_min_lvl),
    .section_en  (section_en),
    .index_bits  (index_bits),
    .size_lvl    (size_lvl),
    .resize_req  (resize_req)
);

// File: tb/cache_resize_ctrl_test.sv
// Directed bench for cache_resize_ctrl: one task per scenario.
module cache_resize_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_pulse = 1'b0;
    logic        retire_pulse = 1'b0;
    logic [19:0] cfg_interval_len = 20'd10;
    logic [15:0] cfg_threshold = 16'd5;
    logic [1:0]  cfg_min_lvl = 2'd1;
    logic [7:0]  section_en;
    logic [3:0]  index_bits;
    logic [1:0]  size_lvl;
    logic        resize_req;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    cache_resize_ctrl uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .miss_pulse       (miss_pulse),
        .retire_pulse     (retire_pulse),
        .cfg_interval_len (cfg_interval_len),
        .cfg_threshold    (cfg_threshold),
        .cfg_min_lvl      (cfg_min_lvl),
        .section_en       (section_en),
        .index_bits       (index_bits),
        .size_lvl         (size_lvl),
        .resize_req       (resize_req)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Check every output against a level; req is the expected pulse value
    task automatic chk_state(input string tag, input int lvl, input int req);
        chk({tag, " R7 mask"}, int'(section_en), (1 << (1 << lvl)) - 1);
        chk({tag, " R8 index"}, int'(index_bits), 7 + lvl);
        chk({tag, " level"}, int'(size_lvl), lvl);
        chk({tag, " R9 req"}, int'(resize_req), req);
    endtask

    // Drive n retires; the last `misses` of them carry a miss; return at the next negedge
    task automatic run_interval(input int n, input int misses);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            retire_pulse = 1'b1;
            miss_pulse   = (i >= n - misses);
        end
        @(negedge clk);
        retire_pulse = 1'b0;
        miss_pulse   = 1'b0;
    endtask

    task automatic t_reset;
        chk_state("R1 reset", 3, 0);
    endtask

    task automatic t_shrink;
        cfg_interval_len = 20'd10; cfg_threshold = 16'd5; cfg_min_lvl = 2'd1;
        run_interval(10, 2);
        chk_state("R4 shrink", 2, 1);
        @(negedge clk);
        chk("R9 pulse ends", int'(resize_req), 0);
    endtask

    task automatic t_equal;
        run_interval(10, 5);
        chk_state("R5 equal holds", 2, 0);
    endtask

    task automatic t_floor;
        run_interval(10, 0);
        chk_state("R4 to floor", 1, 1);
        run_interval(10, 0);
        chk_state("R6 floor holds", 1, 0);
    endtask

    task automatic t_grow;
        run_interval(10, 8);
        chk_state("R3 grow", 2, 1);
        run_interval(10, 8);
        chk_state("R3 grow full", 3, 1);
        run_interval(10, 8);
        chk_state("R3 full holds", 3, 0);
    endtask

    task automatic t_interval_len;
        run_interval(9, 0);
        repeat (5) @(negedge clk);
        chk_state("R2 open interval", 3, 0);
        run_interval(1, 0);
        chk_state("R2 close on last retire", 2, 1);
        cfg_interval_len = 20'd0; cfg_threshold = 16'd0;
        run_interval(1, 1);
        chk_state("R2 zero length", 3, 1);
    endtask

    task automatic t_boundary_miss;
        cfg_interval_len = 20'd4; cfg_threshold = 16'd2;
        run_interval(4, 0);
        chk_state("R10 setup", 2, 1);
        run_interval(4, 3);
        chk_state("R10 closing miss counted", 3, 1);
    endtask

    task automatic t_clear;
        run_interval(4, 4);
        chk_state("R10 hold at full", 3, 0);
        run_interval(4, 0);
        chk_state("R10 misses cleared", 2, 1);
    endtask

    task automatic t_saturate;
        cfg_interval_len = 20'd70000; cfg_threshold = 16'hFFFF;
        run_interval(70000, 70000);
        chk_state("R10 saturates", 2, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shrink();
        t_equal();
        t_floor();
        t_grow();
        t_interval_len();
        t_boundary_miss();
        t_clear();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule